// File: doc/BRIEF.md
# Programmable-Threshold Dual-Clock FIFO Flags

This block is a FIFO that crosses from a write clock to a read clock. Besides empty and full, it gives two early-warning flags, almost-empty and almost-full. Each flag trips at a distance from its boundary that software can set. The pointers cross between the domains in Gray code through two-flop synchronizers. Each side compares its own binary pointer with the synchronized pointer from the other side to get an occupancy figure.

Both thresholds sit in one shift register on a third, slow serial clock. A load enable shifts bits in from a serial data pin, and a separate read enable walks the stored bits out on a serial data pin. The walk does not disturb the stored values. A master reset clears the pointers, latches the read timing mode and loads one of four preset threshold pairs chosen by two select pins. A partial reset clears only the pointers, so the programmed thresholds and the timing mode survive a mid-run flush.

Top module: `prog_flag_fifo`

## Requirements
- R1: While master reset is held, the preset pair is loaded from `preset_sel`: 0→7, 1→63, 2→127, 3→1023, with a value above DEPTH-1 clamped to DEPTH-1, and both thresholds take that same value. After release, empty=1, full=0, ae_n=0, af_n=1, and in standard mode rd_data=0.
- R2: While `sload` is high, each rising `sclk` edge takes one bit from `sdin`. A full load is 2*(AW+1) bits: the almost-empty threshold first, then the almost-full threshold, each least significant bit first.
- R3: While `sread` is high and `sload` is low, `sdout` presents bit k of the R2 sequence after k rising `sclk` edges. Bit 0 appears as soon as `sread` rises. Reading back leaves both thresholds unchanged.
- R4: If `sload` and `sread` are both high, the edge acts as a load exactly as in R2.
- R5: `ae_n` is low exactly when the stored word count is at or below the almost-empty threshold. It changes only on `rclk` edges.
- R6: `af_n` is low exactly when the free space (DEPTH minus the word count) is at or below the almost-full threshold. It changes only on `wclk` edges.
- R7: A write while full and a read while empty are ignored. Words leave in the order they were written, and the occupancy never goes outside 0..DEPTH.
- R8: In standard mode (`rd_mode_sel`=0 at master reset), an accepted read puts the popped word on `rd_data` at the same `rclk` edge that advances the pointer. `rd_data` then holds that word until the next accepted read.
- R9: In show-ahead mode (`rd_mode_sel`=1 at master reset), `rd_data` shows the oldest stored word whenever the FIFO is not empty, and an accepted read moves to the next word.
- R10: Partial reset empties the FIFO (empty=1, ae_n=0) but keeps both thresholds and the timing mode latched by the last master reset.
- R11: Each synchronized pointer changes at most one Gray bit per edge. A write into an empty FIFO clears `empty` no later than the third `rclk` falling edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| sclk | input | 1 | Serial threshold clock |
| mrst | input | 1 | Master reset, synchronous, active high, held across all clocks |
| prst | input | 1 | Partial reset, synchronous, active high, pointers only |
| rd_mode_sel | input | 1 | Timing mode sampled during master reset: 0 standard, 1 show-ahead |
| preset_sel | input | 2 | Preset threshold select sampled during master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write word |
| full | output | 1 | FIFO full, write clock domain |
| af_n | output | 1 | Almost-full, active low, write clock domain |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Read word |
| empty | output | 1 | FIFO empty, read clock domain |
| ae_n | output | 1 | Almost-empty, active low, read clock domain |
| sload | input | 1 | Serial threshold load enable |
| sread | input | 1 | Serial threshold readback enable |
| sdin | input | 1 | Serial threshold data in |
| sdout | output | 1 | Serial threshold data out |

## Verification
A bad pointer or synchronizer value shows at the ports as a flag that disagrees with the number of words written minus words read. The flags are checked at every fill level from 0 to DEPTH, on the way up and on the way down, a few clocks after each step. A corrupted threshold register shows in the serial readback and in the fill level where a flag flips. A lost timing mode or a destructive readback shows within one read or one readback pass after the partial reset or the walk.

// File: rtl/pff_pkg.sv
package pff_pkg;

    localparam int GRAY_MAXW = 16;

    typedef enum logic [1:0] {
        PSEL_7    = 2'd0,
        PSEL_63   = 2'd1,
        PSEL_127  = 2'd2,
        PSEL_1023 = 2'd3
    } preset_e;

    typedef enum logic {
        RD_STANDARD  = 1'b0,
        RD_SHOWAHEAD = 1'b1
    } rd_mode_e;

    function automatic int preset_value(preset_e s);
        case (s)
            PSEL_7:   return 7;
            PSEL_63:  return 63;
            PSEL_127: return 127;
            default:  return 1023;
        endcase
    endfunction

    function automatic int clamp_offset(int v, int depth);
        return (v > depth - 1) ? depth - 1 : v;
    endfunction

    function automatic logic [GRAY_MAXW-1:0] gray2bin(logic [GRAY_MAXW-1:0] g);
        logic [GRAY_MAXW-1:0] b;
        b[GRAY_MAXW-1] = g[GRAY_MAXW-1];
        for (int i = GRAY_MAXW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic logic [GRAY_MAXW-1:0] bin2gray(logic [GRAY_MAXW-1:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/pff_sync2.sv
module pff_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pff_mem.sv
module pff_mem #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/pff_wr_ctl.sv
module pff_wr_ctl
    import pff_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_sync,
    input  logic [AW:0]   af_off,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic          full,
    output logic          af_n
);
    localparam int OW = AW + 1;
    localparam logic [OW-1:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    logic [OW-1:0] wbin, rbin_s, wcount, free_sp, wbin_nx;
    logic          push;

    assign rbin_s  = OW'(gray2bin(GRAY_MAXW'(rgray_sync)));
    assign full    = (wgray == {~rgray_sync[OW-1:OW-2], rgray_sync[OW-3:0]});
    assign push    = wr_en && !full;
    assign we      = push;
    assign waddr   = wbin[AW-1:0];
    assign wcount  = wbin - rbin_s;
    assign free_sp = DEPTH_V - wcount;
    assign wbin_nx = wbin + OW'(1);

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
            af_n  <= 1'b1;
        end else begin
            if (push) begin
                wbin  <= wbin_nx;
                wgray <= OW'(bin2gray(GRAY_MAXW'(wbin_nx)));
            end
            af_n <= !(free_sp <= af_off);
        end
    end

    // R7: occupancy seen from the write side never exceeds the depth
    p_no_overflow_r7: assert property (@(posedge wclk) disable iff (rst)
        wcount <= DEPTH_V);

    // R11: the Gray pointer sent across moves by at most one bit per edge
    p_gray_step_r11: assert property (@(posedge wclk) disable iff (rst)
        !$past(rst) |-> $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/pff_rd_ctl.sv
module pff_rd_ctl
    import pff_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          rclk,
    input  logic          rst,
    input  logic          mrst,
    input  logic          mode_in,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_sync,
    input  logic [AW:0]   ae_off,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic          empty,
    output logic          ae_n,
    output logic [DW-1:0] rd_data
);
    localparam int OW = AW + 1;
    localparam logic [OW-1:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    rd_mode_e      mode_q;
    logic [OW-1:0] rbin, wbin_s, rcount, rbin_nx;
    logic [DW-1:0] rd_q;
    logic          pop;

    assign wbin_s  = OW'(gray2bin(GRAY_MAXW'(wgray_sync)));
    assign empty   = (rgray == wgray_sync);
    assign pop     = rd_en && !empty;
    assign raddr   = rbin[AW-1:0];
    assign rcount  = wbin_s - rbin;
    assign rbin_nx = rbin + OW'(1);
    assign rd_data = (mode_q == RD_SHOWAHEAD) ? mem_rdata : rd_q;

    always_ff @(posedge rclk) begin
        if (mrst) mode_q <= rd_mode_e'(mode_in);
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            rd_q  <= '0;
            ae_n  <= 1'b0;
        end else begin
            if (pop) begin
                rbin  <= rbin_nx;
                rgray <= OW'(bin2gray(GRAY_MAXW'(rbin_nx)));
                rd_q  <= mem_rdata;
            end
            ae_n <= !(rcount <= ae_off);
        end
    end

    // R7: occupancy seen from the read side stays within the depth
    p_no_underflow_r7: assert property (@(posedge rclk) disable iff (rst)
        rcount <= DEPTH_V);

    // R7: an empty FIFO never advances the read pointer
    p_empty_blocks_pop_r7: assert property (@(posedge rclk) disable iff (rst)
        empty |=> $stable(rbin));

    // R10: the timing mode moves only under master reset
    p_mode_hold_r10: assert property (@(posedge rclk) disable iff (mrst)
        !mrst |=> $stable(mode_q));
endmodule

// File: rtl/pff_offsets.sv
module pff_offsets
    import pff_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        sclk,
    input  logic        mrst,
    input  logic [1:0]  preset_sel,
    input  logic        sload,
    input  logic        sread,
    input  logic        sdin,
    output logic        sdout,
    output logic [AW:0] ae_off,
    output logic [AW:0] af_off
);
    localparam int OW    = AW + 1;
    localparam int SW    = 2 * OW;
    localparam int DEPTH = 1 << AW;
    localparam int IW    = $clog2(SW);

    logic [SW-1:0] shreg;
    logic [IW-1:0] idx;
    int            pv;

    always_comb pv = clamp_offset(preset_value(preset_e'(preset_sel)), DEPTH);

    always_ff @(posedge sclk) begin
        if (mrst) begin
            shreg <= {OW'(pv), OW'(pv)};
            idx   <= '0;
        end else if (sload) begin
            shreg <= {sdin, shreg[SW-1:1]};
            idx   <= '0;
        end else if (sread) begin
            idx <= (idx == IW'(SW - 1)) ? '0 : idx + IW'(1);
        end else begin
            idx <= '0;
        end
    end

    assign sdout  = shreg[idx];
    assign ae_off = shreg[OW-1:0];
    assign af_off = shreg[SW-1:OW];

    // R2: each load edge places the serial bit at the top of the chain
    p_load_shift_r2: assert property (@(posedge sclk) disable iff (mrst)
        sload |=> shreg[SW-1] == $past(sdin));

    // R3: without a load the thresholds hold, readback included
    p_readback_keeps_r3: assert property (@(posedge sclk) disable iff (mrst)
        !sload |=> $stable(shreg));

    // R3: the readback position stays inside the chain
    p_idx_range_r3: assert property (@(posedge sclk) disable iff (mrst)
        idx <= IW'(SW - 1));
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
    import pff_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          sclk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          rd_mode_sel,
    input  logic [1:0]    preset_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    output logic          af_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          ae_n,
    input  logic          sload,
    input  logic          sread,
    input  logic          sdin,
    output logic          sdout
);
    localparam int OW = AW + 1;

    logic          ptr_rst;
    logic [OW-1:0] wgray, rgray, wgray_s, rgray_s, ae_off, af_off;
    logic [AW-1:0] waddr, raddr;
    logic          we;
    logic [DW-1:0] mem_rdata;

    assign ptr_rst = mrst | prst;

    pff_offsets #(.AW(AW)) u_offsets (
        .sclk       (sclk),
        .mrst       (mrst),
        .preset_sel (preset_sel),
        .sload      (sload),
        .sread      (sread),
        .sdin       (sdin),
        .sdout      (sdout),
        .ae_off     (ae_off),
        .af_off     (af_off)
    );

    pff_sync2 #(.W(OW)) u_sync_r2w (
        .clk (wclk),
        .rst (ptr_rst),
        .d   (rgray),
        .q   (rgray_s)
    );

    pff_sync2 #(.W(OW)) u_sync_w2r (
        .clk (rclk),
        .rst (ptr_rst),
        .d   (wgray),
        .q   (wgray_s)
    );

    pff_wr_ctl #(.AW(AW)) u_wr (
        .wclk       (wclk),
        .rst        (ptr_rst),
        .wr_en      (wr_en),
        .rgray_sync (rgray_s),
        .af_off     (af_off),
        .wgray      (wgray),
        .waddr      (waddr),
        .we         (we),
        .full       (full),
        .af_n       (af_n)
    );

    pff_mem #(.AW(AW), .DW(DW)) u_mem (
        .wclk  (wclk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    pff_rd_ctl #(.AW(AW), .DW(DW)) u_rd (
        .rclk       (rclk),
        .rst        (ptr_rst),
        .mrst       (mrst),
        .mode_in    (rd_mode_sel),
        .rd_en      (rd_en),
        .wgray_sync (wgray_s),
        .ae_off     (ae_off),
        .mem_rdata  (mem_rdata),
        .rgray      (rgray),
        .raddr      (raddr),
        .empty      (empty),
        .ae_n       (ae_n),
        .rd_data    (rd_data)
    );
endmodule

// File: tb/prog_flag_fifo_tb.sv
module prog_flag_fifo_tb;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int OW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic wclk = 0, rclk = 0, sclk = 0;
    logic mrst = 1, prst = 0, rd_mode_sel = 0;
    logic [1:0] preset_sel = 0;
    logic wr_en = 0, rd_en = 0, sload = 0, sread = 0, sdin = 0;
    logic [DW-1:0] wr_data = 0;
    logic full, af_n, empty, ae_n, sdout;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #2 wclk = ~wclk;
    always #3 rclk = ~rclk;
    always #5 sclk = ~sclk;

    prog_flag_fifo #(.AW(AW), .DW(DW)) u_dut (
        .wclk(wclk), .rclk(rclk), .sclk(sclk), .mrst(mrst), .prst(prst),
        .rd_mode_sel(rd_mode_sel), .preset_sel(preset_sel),
        .wr_en(wr_en), .wr_data(wr_data), .full(full), .af_n(af_n),
        .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .ae_n(ae_n),
        .sload(sload), .sread(sread), .sdin(sdin), .sdout(sdout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
    endtask

    task automatic do_mrst(input int sel, input logic mode);
        @(negedge sclk);
        mrst = 1; preset_sel = sel[1:0]; rd_mode_sel = mode;
        repeat (4) @(negedge sclk);
        mrst = 0;
        settle();
    endtask

    task automatic do_prst();
        @(negedge sclk);
        prst = 1;
        repeat (4) @(negedge sclk);
        prst = 0;
        settle();
    endtask

    task automatic write_word(input logic [DW-1:0] d);
        @(negedge wclk); wr_en = 1; wr_data = d;
        @(negedge wclk); wr_en = 0;
    endtask

    task automatic pop_std(output logic [DW-1:0] d);
        @(negedge rclk); rd_en = 1;
        @(negedge rclk); rd_en = 0; d = rd_data;
    endtask

    task automatic serial_load(input int ae, input int af, input logic with_read);
        logic [2*OW-1:0] bits;
        bits = {af[OW-1:0], ae[OW-1:0]};
        @(negedge sclk); sload = 1; sread = with_read; sdin = bits[0];
        for (int i = 1; i < 2*OW; i++) begin
            @(negedge sclk); sdin = bits[i];
        end
        @(negedge sclk); sload = 0; sread = 0;
    endtask

    task automatic serial_read(output int ae, output int af);
        logic [2*OW-1:0] got;
        @(negedge sclk); sread = 1;
        for (int i = 0; i < 2*OW; i++) begin
            got[i] = sdout;
            @(negedge sclk);
        end
        sread = 0;
        @(negedge sclk);
        ae = int'(got[OW-1:0]);
        af = int'(got[2*OW-1:OW]);
    endtask

    task automatic chk_flags(input string req, input int n, input int ae, input int af);
        chk({req, " ae_n"}, ae_n, (n <= ae) ? 0 : 1);
        chk({req, " af_n"}, af_n, ((DEPTH - n) <= af) ? 0 : 1);
    endtask

    initial begin
        #600000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int ra, rf, ra2, rf2, k;
        logic [DW-1:0] d;
        int ae_set[5] = '{0, 3, 7, 15, 20};
        int af_set[5] = '{0, 5, 2, 15, 1};

        // R1: reset state and preset pairs
        for (int s = 0; s < 4; s++) begin
            int pv;
            pv = (s == 0) ? 7 : (s == 1) ? 63 : (s == 2) ? 127 : 1023;
            if (pv > DEPTH - 1) pv = DEPTH - 1;
            do_mrst(s, 0);
            chk("R1 empty", empty, 1);
            chk("R1 full", full, 0);
            chk("R1 ae_n", ae_n, 0);
            chk("R1 af_n", af_n, 1);
            chk("R1 rd_data", rd_data, 0);
            serial_read(ra, rf);
            chk("R1 preset ae", ra, pv);
            chk("R1 preset af", rf, pv);
        end

        // R2 R5 R6 R7 R8: threshold sweep over every fill level
        for (int p = 0; p < 5; p++) begin
            do_mrst(0, 0);
            serial_load(ae_set[p], af_set[p], 0);
            serial_read(ra, rf);
            chk("R2 load ae", ra, ae_set[p]);
            chk("R2 load af", rf, af_set[p]);
            settle();
            for (int n = 0; n <= DEPTH; n++) begin
                chk_flags("R5 R6 fill", n, ae_set[p], af_set[p]);
                if (n < DEPTH) begin
                    write_word(DW'(n + 16 * p));
                    settle();
                end
            end
            chk("R7 full", full, 1);
            write_word(8'hEE);
            settle();
            chk("R7 full after extra write", full, 1);
            for (int i = 0; i < DEPTH; i++) begin
                pop_std(d);
                chk("R8 order", d, DW'(i + 16 * p));
                settle();
                chk_flags("R5 R6 drain", DEPTH - 1 - i, ae_set[p], af_set[p]);
            end
            chk("R7 empty after drain", empty, 1);
            pop_std(d);
            chk("R7 pop on empty keeps data", d, DW'(DEPTH - 1 + 16 * p));
            write_word(8'hAB);
            settle();
            pop_std(d);
            chk("R7 no phantom word", d, 8'hAB);
        end

        // R4: load wins over readback
        serial_load(9, 4, 1);
        serial_read(ra, rf);
        chk("R4 ae", ra, 9);
        chk("R4 af", rf, 4);

        // R3: readback is non-destructive
        serial_read(ra2, rf2);
        chk("R3 ae reread", ra2, 9);
        chk("R3 af reread", rf2, 4);

        // R9: show-ahead mode
        do_mrst(0, 1);
        for (int i = 0; i < 3; i++) write_word(DW'(8'h10 + i));
        settle();
        for (int i = 0; i < 3; i++) begin
            @(negedge rclk);
            chk("R9 head word", rd_data, 8'h10 + i);
            rd_en = 1;
            @(negedge rclk); rd_en = 0;
        end
        settle();
        chk("R9 empty", empty, 1);

        // R10: partial reset keeps thresholds and mode
        serial_load(5, 6, 0);
        for (int i = 0; i < 6; i++) write_word(DW'(8'h30 + i));
        settle();
        chk("R10 ae_n before", ae_n, 1);
        do_prst();
        chk("R10 empty", empty, 1);
        chk("R10 ae_n", ae_n, 0);
        chk("R10 full", full, 0);
        serial_read(ra, rf);
        chk("R10 ae kept", ra, 5);
        chk("R10 af kept", rf, 6);
        write_word(8'h55);
        settle();
        chk("R10 show-ahead kept", rd_data, 8'h55);

        // R11: empty latency after a write
        do_mrst(0, 0);
        @(negedge wclk); wr_en = 1; wr_data = 8'h77;
        @(posedge wclk); #1 wr_en = 0;
        k = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge rclk);
            if (!empty && k == 0) k = i;
        end
        chk("R11 empty clears", (k >= 1 && k <= 3) ? 1 : 0, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule